// File: doc/BRIEF.md
# CAN Message Object Flag Controller

This block keeps the five status flags of every object in a bank of CAN message objects. The flags are valid, new data, message lost, interrupt pending and transmit request. It sits between a CAN protocol core and a CPU. The core reports received frames, the start of a transmission and the end of a transmission as one-cycle strobes. The CPU writes or clears flags of one object at a time. The identifier, mask and enable bits of each object arrive as flat configuration vectors from the surrounding message storage.

A received frame is steered to the lowest-numbered valid object whose identifier matches. For that object the block reports the target index one cycle later and updates its flags. A data frame marks the object as holding new data and detects an overrun. A remote frame may raise the object's transmit request. Two lowest-index-wins selectors run continuously on the flag registers. One names the next object to transmit. The other names the object that owns the highest-priority pending interrupt, encoded as an interrupt identifier.

A transmission in flight is tied to the object that was selected when it started. If the CPU refreshes that object's data before the frame ends, the transmit request is kept so that the new data is sent as well.

Top module: `msgobj_flag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all five flags of every object, drives `int_id` to 0, `tx_sel_vld` to 0 and `rx_hit` to 0.
- R2: A strobe on `rx_vld` selects the lowest-numbered valid object whose identifier equals `rx_id` on every bit where the care mask is 1. The care mask is the object's mask when its use-mask bit is 1, and all ones otherwise. On the next cycle `rx_hit` shows whether an object matched and `rx_obj` gives its index.
- R3: A matched data frame (`rx_remote`=0) sets new-data and clears transmit-request of the target object. It sets interrupt-pending only when that object's receive-interrupt enable is 1.
- R4: If new-data of the target is already 1 when a data frame is stored, message-lost is set. Message-lost is cleared only by a CPU write or clear.
- R5: A matched remote frame (`rx_remote`=1) sets transmit-request when the object's remote-enable is 1. Otherwise transmit-request is unchanged. New-data is not touched by a remote frame.
- R6: `tx_sel` is the lowest-numbered object with both valid and transmit-request set, and `tx_sel_vld` is 1 when such an object exists. Both follow the flag registers without an input path.
- R7: `tx_start` while `tx_sel_vld` is 1 clears new-data of the object named by `tx_sel`. That object is then recorded as in flight.
- R8: `tx_done` with `tx_ok`=1 affects the in-flight object. Transmit-request is cleared only if new-data is 0, and interrupt-pending is set if the transmit-interrupt enable is 1. With `tx_ok`=0 no flag changes.
- R9: `int_id` is 0 when no interrupt-pending flag is set. Otherwise it is 1 plus the lowest index with interrupt-pending set. It reflects a CPU clear in the cycle after the strobe.
- R10: The CPU flag vectors use bit 4 for valid, bit 3 for new-data, bit 2 for message-lost, bit 1 for interrupt-pending and bit 0 for transmit-request. `cpu_wr` replaces all five flags of `cpu_obj` with `cpu_flags`. `cpu_clr` clears the flags of `cpu_obj` whose bit in `cpu_flags` is 1. A CPU update is applied before any core event on the same object in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_id | input | NUM_OBJ*ID_W | Identifier of each object, object i at bits [i*ID_W +: ID_W] |
| cfg_mask | input | NUM_OBJ*ID_W | Acceptance care mask of each object, same packing as `cfg_id` |
| cfg_umask | input | NUM_OBJ | Use-mask bit per object |
| cfg_rxie | input | NUM_OBJ | Receive-interrupt enable per object |
| cfg_txie | input | NUM_OBJ | Transmit-interrupt enable per object |
| cfg_rmten | input | NUM_OBJ | Remote-enable per object |
| rx_vld | input | 1 | One-cycle strobe: a received frame is ready for filtering |
| rx_id | input | ID_W | Identifier of the received frame |
| rx_remote | input | 1 | 1 for a remote frame, 0 for a data frame |
| tx_start | input | 1 | One-cycle strobe: transmission of `tx_sel` begins |
| tx_done | input | 1 | One-cycle strobe: the in-flight transmission ended |
| tx_ok | input | 1 | Qualifies `tx_done`: 1 for success |
| cpu_wr | input | 1 | CPU write strobe for the flags of `cpu_obj` |
| cpu_clr | input | 1 | CPU clear strobe for the flags of `cpu_obj` |
| cpu_obj | input | IDX_W | Object index addressed by the CPU |
| cpu_flags | input | 5 | Flag values for a write, or clear mask for a clear |
| obj_valid | output | NUM_OBJ | Valid flag of each object |
| obj_newdat | output | NUM_OBJ | New-data flag of each object |
| obj_msglost | output | NUM_OBJ | Message-lost flag of each object |
| obj_intpnd | output | NUM_OBJ | Interrupt-pending flag of each object |
| obj_txrqst | output | NUM_OBJ | Transmit-request flag of each object |
| tx_sel | output | IDX_W | Index of the next object to transmit |
| tx_sel_vld | output | 1 | An object is waiting to transmit |
| int_id | output | INT_W | Interrupt identifier, 0 or object index plus 1 |
| rx_hit | output | 1 | The previous received frame matched an object |
| rx_obj | output | IDX_W | Index of the object that took the previous frame |

## Verification
Received identifiers are chosen so that two valid objects match at once. Some differ only in bits the mask ignores, and some have use-mask off. This separates lowest-index priority, masked comparison and exact comparison, and a miss proves the mask is ignored when use-mask is 0. Repeated data frames to one object separate a first store from an overrun. A CPU write that lands in the same cycle as a frame shows the order of updates. Transmissions are run with and without a data refresh during the frame and with a failed end. Together these separate the cleared and kept transmit request. Interrupt clears walk the identifier down through several owners to zero.

// File: rtl/msgobj_pkg.sv
package msgobj_pkg;
  typedef struct packed {
    logic vld;
    logic nd;
    logic ml;
    logic ip;
    logic txrq;
  } obj_flags_t;

  localparam int FLAG_W = 5;
endpackage

// File: rtl/msgobj_lowest_sel.sv
module msgobj_lowest_sel #(
  parameter int N    = 32,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/msgobj_accept_filter.sv
module msgobj_accept_filter #(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 29,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic [ID_W-1:0]         rx_id,
  input  logic [NUM_OBJ*ID_W-1:0] cfg_id,
  input  logic [NUM_OBJ*ID_W-1:0] cfg_mask,
  input  logic [NUM_OBJ-1:0]      cfg_umask,
  input  logic [NUM_OBJ-1:0]      obj_valid,
  output logic                    hit,
  output logic [IDX_W-1:0]        obj
);
  logic [NUM_OBJ-1:0] match;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
    logic [ID_W-1:0] care;
    assign care     = cfg_umask[g] ? cfg_mask[g*ID_W +: ID_W] : {ID_W{1'b1}};
    assign match[g] = obj_valid[g] &&
                      (((cfg_id[g*ID_W +: ID_W] ^ rx_id) & care) == '0);
  end

  msgobj_lowest_sel #(.N(NUM_OBJ), .IW(IDX_W)) u_pick (
    .req   (match),
    .found (hit),
    .idx   (obj)
  );
endmodule

// File: rtl/msgobj_flag_cell.sv
module msgobj_flag_cell
  import msgobj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_wr_hit,
  input  logic       cpu_clr_hit,
  input  obj_flags_t cpu_val,
  input  logic       txs_hit,
  input  logic       txd_hit,
  input  logic       rxd_hit,
  input  logic       rmt_hit,
  input  logic       txie,
  input  logic       rxie,
  input  logic       rmten,
  output obj_flags_t flags_o
);
  obj_flags_t q, d;

  always_comb begin
    d = q;
    if (cpu_wr_hit) d = cpu_val;
    if (cpu_clr_hit) d = d & ~cpu_val;
    if (txs_hit) d.nd = 1'b0;
    if (txd_hit) begin
      if (!d.nd) d.txrq = 1'b0;
      if (txie)  d.ip   = 1'b1;
    end
    if (rxd_hit) begin
      if (d.nd) d.ml = 1'b1;
      d.nd   = 1'b1;
      d.txrq = 1'b0;
      if (rxie) d.ip = 1'b1;
    end
    if (rmt_hit && rmten) d.txrq = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  assign flags_o = q;

  AST_OVERRUN_SETS_LOST: assert property (@(posedge clk) disable iff (rst)
    rxd_hit && q.nd && !cpu_wr_hit && !cpu_clr_hit && !txs_hit |=> q.ml); // R4
  AST_TXSTART_CLEARS_ND: assert property (@(posedge clk) disable iff (rst)
    txs_hit && !rxd_hit |=> !q.nd); // R7
  AST_TX_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
    txd_hit && q.nd && !cpu_wr_hit && !cpu_clr_hit && !txs_hit && !rxd_hit && !rmt_hit
    |=> $stable(q.txrq)); // R8
  AST_REMOTE_SETS_REQ: assert property (@(posedge clk) disable iff (rst)
    rmt_hit && rmten |=> q.txrq); // R5
  AST_DATA_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
    rxd_hit |=> q.nd && !q.txrq); // R3
endmodule

// File: rtl/msgobj_flag_ctrl.sv
module msgobj_flag_ctrl
  import msgobj_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 29,
  parameter int INT_W   = 16,
  localparam int IDX_W  = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_OBJ*ID_W-1:0] cfg_id,
  input  logic [NUM_OBJ*ID_W-1:0] cfg_mask,
  input  logic [NUM_OBJ-1:0]      cfg_umask,
  input  logic [NUM_OBJ-1:0]      cfg_rxie,
  input  logic [NUM_OBJ-1:0]      cfg_txie,
  input  logic [NUM_OBJ-1:0]      cfg_rmten,
  input  logic                    rx_vld,
  input  logic [ID_W-1:0]         rx_id,
  input  logic                    rx_remote,
  input  logic                    tx_start,
  input  logic                    tx_done,
  input  logic                    tx_ok,
  input  logic                    cpu_wr,
  input  logic                    cpu_clr,
  input  logic [IDX_W-1:0]        cpu_obj,
  input  logic [FLAG_W-1:0]       cpu_flags,
  output logic [NUM_OBJ-1:0]      obj_valid,
  output logic [NUM_OBJ-1:0]      obj_newdat,
  output logic [NUM_OBJ-1:0]      obj_msglost,
  output logic [NUM_OBJ-1:0]      obj_intpnd,
  output logic [NUM_OBJ-1:0]      obj_txrqst,
  output logic [IDX_W-1:0]        tx_sel,
  output logic                    tx_sel_vld,
  output logic [INT_W-1:0]        int_id,
  output logic                    rx_hit,
  output logic [IDX_W-1:0]        rx_obj
);
  logic             flt_hit;
  logic [IDX_W-1:0] flt_obj;
  logic             fly_vld;
  logic [IDX_W-1:0] fly_obj;
  logic             int_found;
  logic [IDX_W-1:0] int_idx;
  logic             tx_go;

  msgobj_accept_filter #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_filter (
    .rx_id     (rx_id),
    .cfg_id    (cfg_id),
    .cfg_mask  (cfg_mask),
    .cfg_umask (cfg_umask),
    .obj_valid (obj_valid),
    .hit       (flt_hit),
    .obj       (flt_obj)
  );

  assign tx_go = tx_start && tx_sel_vld;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    obj_flags_t fl;
    logic       sel_cpu, sel_flt;
    assign sel_cpu = (cpu_obj == IDX_W'(g));
    assign sel_flt = rx_vld && flt_hit && (flt_obj == IDX_W'(g));

    msgobj_flag_cell u_cell (
      .clk         (clk),
      .rst         (rst),
      .cpu_wr_hit  (cpu_wr && sel_cpu),
      .cpu_clr_hit (cpu_clr && sel_cpu),
      .cpu_val     (obj_flags_t'(cpu_flags)),
      .txs_hit     (tx_go && (tx_sel == IDX_W'(g))),
      .txd_hit     (tx_done && tx_ok && fly_vld && (fly_obj == IDX_W'(g))),
      .rxd_hit     (sel_flt && !rx_remote),
      .rmt_hit     (sel_flt && rx_remote),
      .txie        (cfg_txie[g]),
      .rxie        (cfg_rxie[g]),
      .rmten       (cfg_rmten[g]),
      .flags_o     (fl)
    );

    assign obj_valid[g]   = fl.vld;
    assign obj_newdat[g]  = fl.nd;
    assign obj_msglost[g] = fl.ml;
    assign obj_intpnd[g]  = fl.ip;
    assign obj_txrqst[g]  = fl.txrq;
  end

  msgobj_lowest_sel #(.N(NUM_OBJ), .IW(IDX_W)) u_txpick (
    .req   (obj_valid & obj_txrqst),
    .found (tx_sel_vld),
    .idx   (tx_sel)
  );

  msgobj_lowest_sel #(.N(NUM_OBJ), .IW(IDX_W)) u_intpick (
    .req   (obj_intpnd),
    .found (int_found),
    .idx   (int_idx)
  );

  assign int_id = int_found ? (INT_W'(int_idx) + INT_W'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fly_vld <= 1'b0;
      fly_obj <= '0;
      rx_hit  <= 1'b0;
      rx_obj  <= '0;
    end else begin
      if (tx_go) begin
        fly_vld <= 1'b1;
        fly_obj <= tx_sel;
      end else if (tx_done) begin
        fly_vld <= 1'b0;
      end
      rx_hit <= rx_vld && flt_hit;
      if (rx_vld && flt_hit) rx_obj <= flt_obj;
    end
  end

  AST_INTID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int_id <= INT_W'(NUM_OBJ)); // R9
  AST_TXSEL_PENDING: assert property (@(posedge clk) disable iff (rst)
    tx_sel_vld |-> obj_valid[tx_sel] && obj_txrqst[tx_sel]); // R6
  AST_RX_TARGET_VALID: assert property (@(posedge clk) disable iff (rst)
    rx_vld && flt_hit |-> obj_valid[flt_obj]); // R2
  AST_INTID_OWNER: assert property (@(posedge clk) disable iff (rst)
    int_id != '0 |-> obj_intpnd[int_id - INT_W'(1)]); // R9
endmodule

// File: tb/msgobj_flag_ctrl_bench.sv
`timescale 1ns/1ps
module msgobj_flag_ctrl_bench;
  localparam int NUM_OBJ = 32;
  localparam int ID_W    = 29;
  localparam int INT_W   = 16;
  localparam int IDX_W   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_OBJ*ID_W-1:0] cfg_id, cfg_mask;
  logic [NUM_OBJ-1:0] cfg_umask, cfg_rxie, cfg_txie, cfg_rmten;
  logic rx_vld = 0, rx_remote = 0, tx_start = 0, tx_done = 0, tx_ok = 0;
  logic cpu_wr = 0, cpu_clr = 0;
  logic [ID_W-1:0] rx_id = '0;
  logic [IDX_W-1:0] cpu_obj = '0;
  logic [4:0] cpu_flags = '0;
  logic [NUM_OBJ-1:0] obj_valid, obj_newdat, obj_msglost, obj_intpnd, obj_txrqst;
  logic [IDX_W-1:0] tx_sel, rx_obj;
  logic tx_sel_vld, rx_hit;
  logic [INT_W-1:0] int_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  msgobj_flag_ctrl #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .INT_W(INT_W)) u_msgobj_flag_ctrl (
    .clk(clk), .rst(rst), .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cfg_umask(cfg_umask),
    .cfg_rxie(cfg_rxie), .cfg_txie(cfg_txie), .cfg_rmten(cfg_rmten),
    .rx_vld(rx_vld), .rx_id(rx_id), .rx_remote(rx_remote),
    .tx_start(tx_start), .tx_done(tx_done), .tx_ok(tx_ok),
    .cpu_wr(cpu_wr), .cpu_clr(cpu_clr), .cpu_obj(cpu_obj), .cpu_flags(cpu_flags),
    .obj_valid(obj_valid), .obj_newdat(obj_newdat), .obj_msglost(obj_msglost),
    .obj_intpnd(obj_intpnd), .obj_txrqst(obj_txrqst), .tx_sel(tx_sel),
    .tx_sel_vld(tx_sel_vld), .int_id(int_id), .rx_hit(rx_hit), .rx_obj(rx_obj)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input int obj, input logic [4:0] f);
    @(negedge clk);
    cpu_wr = 1; cpu_obj = IDX_W'(obj); cpu_flags = f;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic cpu_clear(input int obj, input logic [4:0] m);
    @(negedge clk);
    cpu_clr = 1; cpu_obj = IDX_W'(obj); cpu_flags = m;
    @(negedge clk);
    cpu_clr = 0;
  endtask

  task automatic rx_frame(input logic [ID_W-1:0] id, input logic rmt);
    @(negedge clk);
    rx_vld = 1; rx_id = id; rx_remote = rmt;
    @(negedge clk);
    rx_vld = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    tx_start = 1;
    @(negedge clk);
    tx_start = 0;
  endtask

  task automatic pulse_done(input logic ok);
    @(negedge clk);
    tx_done = 1; tx_ok = ok;
    @(negedge clk);
    tx_done = 0; tx_ok = 0;
  endtask

  task automatic t_reset();
    chk("R1", "valid", obj_valid, 0);
    chk("R1", "newdat|msglost|intpnd|txrqst",
        obj_newdat | obj_msglost | obj_intpnd | obj_txrqst, 0);
    chk("R1", "int_id", int_id, 0);
    chk("R1", "tx_sel_vld", tx_sel_vld, 0);
    chk("R1", "rx_hit", rx_hit, 0);
  endtask

  task automatic t_filter();
    foreach (cfg_umask[i]) if (i inside {3, 5, 7, 9, 10, 12, 13}) cpu_write(i, 5'b10000);
    chk("R10", "valid after writes", obj_valid, 32'h0000_36A8);
    rx_frame(29'h100, 0);
    chk("R2", "hit lowest of 3,5", rx_hit, 1);
    chk("R2", "obj lowest of 3,5", rx_obj, 3);
    chk("R3", "newdat 3", obj_newdat[3], 1);
    chk("R3", "intpnd 3 rxie", obj_intpnd[3], 1);
    chk("R9", "int_id obj3", int_id, 4);
    rx_frame(29'h205, 0);
    chk("R2", "masked match obj7", rx_obj, 7);
    chk("R3", "intpnd 7 rxie off", obj_intpnd[7], 0);
    rx_frame(29'h100, 0);
    chk("R4", "msglost 3 overrun", obj_msglost[3], 1);
    chk("R4", "msglost 7 single store", obj_msglost[7], 0);
    cpu_write(3, 5'b00000);
    chk("R4", "msglost 3 cleared by cpu", obj_msglost[3], 0);
    chk("R9", "int_id none", int_id, 0);
    cpu_write(5, 5'b10001);
    rx_frame(29'h100, 0);
    chk("R2", "obj5 after 3 invalid", rx_obj, 5);
    chk("R3", "txrqst 5 cleared", obj_txrqst[5], 0);
    chk("R3", "newdat 5", obj_newdat[5], 1);
    chk("R3", "intpnd 5 rxie off", obj_intpnd[5], 0);
    cpu_write(7, 5'b00000);
    rx_frame(29'h205, 0);
    chk("R2", "exact match obj9", rx_obj, 9);
    rx_frame(29'h206, 0);
    chk("R2", "no hit without mask", rx_hit, 0);
  endtask

  task automatic t_order();
    @(negedge clk);
    cpu_wr = 1; cpu_obj = 5; cpu_flags = 5'b10000;
    rx_vld = 1; rx_id = 29'h100; rx_remote = 0;
    @(negedge clk);
    cpu_wr = 0; rx_vld = 0;
    chk("R10", "newdat 5 hw after cpu", obj_newdat[5], 1);
    chk("R10", "msglost 5 no overrun", obj_msglost[5], 0);
  endtask

  task automatic t_remote();
    rx_frame(29'h300, 1);
    chk("R5", "txrqst 12 remote", obj_txrqst[12], 1);
    chk("R5", "newdat 12 untouched", obj_newdat[12], 0);
    rx_frame(29'h301, 1);
    chk("R5", "txrqst 13 remote disabled", obj_txrqst[13], 0);
  endtask

  task automatic t_txsel();
    chk("R6", "tx_sel 12", {tx_sel_vld, 3'b0, tx_sel}, {1'b1, 3'b0, 5'd12});
    cpu_write(11, 5'b00001);
    chk("R6", "invalid 11 skipped", tx_sel, 12);
    cpu_write(10, 5'b11001);
    chk("R6", "tx_sel 10", tx_sel, 10);
  endtask

  task automatic t_tx();
    pulse_start();
    chk("R7", "newdat 10 cleared", obj_newdat[10], 0);
    chk("R7", "txrqst 10 held in flight", obj_txrqst[10], 1);
    pulse_done(1);
    chk("R8", "txrqst 10 cleared", obj_txrqst[10], 0);
    chk("R8", "intpnd 10 txie", obj_intpnd[10], 1);
    chk("R9", "int_id 11", int_id, 11);
    chk("R6", "tx_sel 12 again", tx_sel, 12);
    pulse_start();
    cpu_write(12, 5'b11001);
    pulse_done(1);
    chk("R8", "txrqst 12 kept after refresh", obj_txrqst[12], 1);
    chk("R8", "intpnd 12 txie", obj_intpnd[12], 1);
    chk("R9", "int_id stays 11", int_id, 11);
    pulse_start();
    chk("R7", "newdat 12 cleared", obj_newdat[12], 0);
    pulse_done(0);
    chk("R8", "txrqst 12 after failure", obj_txrqst[12], 1);
  endtask

  task automatic t_int();
    cpu_clear(10, 5'b00010);
    chk("R9", "int_id 13 after clear", int_id, 13);
    cpu_clear(12, 5'b00011);
    chk("R9", "int_id 0 after clear", int_id, 0);
    chk("R6", "none pending", tx_sel_vld, 0);
    chk("R10", "valid 12 kept by clear", obj_valid[12], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_OBJ; i++) begin
      cfg_id[i*ID_W +: ID_W]   = ID_W'(32'h1000 + i);
      cfg_mask[i*ID_W +: ID_W] = '1;
    end
    cfg_id[3*ID_W +: ID_W]  = 29'h100;
    cfg_id[5*ID_W +: ID_W]  = 29'h100;
    cfg_id[7*ID_W +: ID_W]  = 29'h200;
    cfg_mask[7*ID_W +: ID_W] = 29'h1FFF_FFF0;
    cfg_id[9*ID_W +: ID_W]  = 29'h205;
    cfg_mask[9*ID_W +: ID_W] = 29'h1FFF_FFF0;
    cfg_id[12*ID_W +: ID_W] = 29'h300;
    cfg_id[13*ID_W +: ID_W] = 29'h301;
    cfg_umask = 32'h0000_0080;
    cfg_rxie  = 32'h0000_0008;
    cfg_txie  = 32'h0000_1400;
    cfg_rmten = 32'h0000_1000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_filter();
    t_order();
    t_remote();
    t_txsel();
    t_tx();
    t_int();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule